// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block plays the memory side of a two-wire serial EEPROM. It runs in one clock domain. Each clock it looks at the clock line and data line levels, which are already synchronised and oversampled. From them it finds start and stop conditions, counts the bit clocks of a transfer and tracks the word address. Written bytes go into an internal byte array, and read bytes come back one bit per clock on a read-data output. That output is driven low in acknowledge slots and follows the data line when the device is idle.

A mode input selects one of three address formats:
- **Legacy:** the first byte carries the word address and the direction. There is no device byte.
- **One address byte:** a device byte is followed by one address byte. Three device-byte bits extend the address.
- **Two address bytes:** a device byte is followed by two address bytes.

Each format has its own page size for writes, and its own rule for how the address advances on reads.

Top module: `twi_eeprom_slave`

## Requirements
- R1: While `scl_i` stays high, `sda_i` going 1→0 starts a transfer and sets the bit count to 0. A repeated start inside a transfer does the same.
- R2: While `scl_i` stays high, `sda_i` going 0→1 ends the transfer. While idle, toggling `scl_i` with `sda_i` held high leaves the device idle: `ack_o` stays 0 and the read output keeps following `sda_i`.
- R3: During a transfer, each rising edge of `scl_i` adds one to the bit count, and each falling edge of `scl_i` samples `sda_i` as the incoming bit.
- R4: At counts 9, 18 and 27, `ack_o` is 1 and `sda_rd_o` is 0. At every other count `ack_o` is 0.
- R5: Legacy mode is `mode_i` = 0. The first byte is sent MSB first: seven word-address bits, then the direction bit, where 1 means read. Count 18 folds back to 9.
- R6: In legacy mode a read advances the word address by one per byte, and address 127 is followed by address 0.
- R7: In legacy mode a written byte is stored after its eighth bit. Only the low 2 address bits then advance, so writes wrap inside an aligned 4-byte page.
- R8: `mode_i` = 1 selects one address byte. `mode_i` = 2 or 3 selects two address bytes. The device byte uses counts 1–8, and its LSB is the direction bit, where 1 means read. The address byte uses counts 10–17, MSB first. The second address byte, high byte first, uses counts 19–26. Data bits come after the address.
- R9: In the device-byte modes a read folds count 18 back to 9 and advances the full 13-bit address by one, crossing page boundaries. A write folds count 27 back to 18 when `mode_i` = 1, and count 36 back to 27 when `mode_i` = 2 or 3.
- R10: In the device-byte modes a written byte advances only the low 4 address bits, so writes wrap inside an aligned 16-byte page.
- R11: When `mode_i` = 1, device-byte bits 3:1 become word-address bits 10:8 once the address byte is complete. The array is indexed by the word address modulo `MEM_BYTES`.
- R12: Read data leaves MSB first during counts 10–17, and count c carries bit 17−c of the addressed byte. When idle, `sda_rd_o` equals `sda_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Address format: 0 legacy, 1 one address byte, 2 or 3 two address bytes |
| scl_i | input | 1 | Sampled serial clock level |
| sda_i | input | 1 | Sampled serial data level |
| sda_rd_o | output | 1 | Data bit driven by the slave |
| ack_o | output | 1 | High during an acknowledge slot |

## Verification
The hardest case to reach is the one-address-byte fold. It only shows when bits 3:1 of the device byte are non-zero and the array is larger than 256 bytes. The bench therefore builds a 2048-byte array and writes through the one-address-byte mode. It then reads the same byte back in two ways: through a repeated start in the same mode, and by its full address in the two-address-byte mode. A different value is placed first at the unfolded address, so that a missing fold shows up. Page wraps are reached by writing past the end of a page and then reading the whole page back. The legacy 127→0 read wrap is reached by a sequential read that starts at the last byte.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    localparam int CNT_W   = 6;   // bit count reaches at most 35
    localparam int WADDR_W = 13;  // widest word address
    localparam int DATA_W  = 8;

    typedef struct packed {
        logic               started;
        logic               scl;      // previous sampled clock level
        logic               sda;      // previous sampled data level
        logic [CNT_W-1:0]   cnt;
        logic [3:0]         dev;      // device-byte bits 3:0 (bit 0 = read)
        logic [WADDR_W-1:0] addr;
        logic [DATA_W-2:0]  shreg;    // first seven bits of an incoming byte
    } slv_state_t;

endpackage

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
    input  logic scl_prev_i,
    input  logic sda_prev_i,
    input  logic scl_i,
    input  logic sda_i,
    input  logic started_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_held;

    always_comb begin
        scl_held = scl_prev_i & scl_i;
        start_o  = scl_held & sda_prev_i & ~sda_i;
        stop_o   = scl_held & ~sda_prev_i & sda_i;
        rise_o   = ~scl_held & started_i & ~scl_prev_i & scl_i;
        fall_o   = ~scl_held & started_i & scl_prev_i & ~scl_i;
    end
endmodule

// File: rtl/twi_byte_store.sv
module twi_byte_store #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_eeprom_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_rd_o,
    output logic       ack_o
);
    slv_state_t st_d, st_q;

    logic              cond_start, cond_stop, scl_rise, scl_fall;
    logic              mode_legacy, mode_two;
    logic [CNT_W-1:0]  cnt_inc;
    logic [WADDR_W-1:0] addr_sh, idx_full;
    logic              is_ack, data_phase, read_dir;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [AW-1:0]     mem_idx;
    logic [2:0]        bit_sel;

    twi_cond_detect u_cond (
        .scl_prev_i (st_q.scl),
        .sda_prev_i (st_q.sda),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .started_i  (st_q.started),
        .start_o    (cond_start),
        .stop_o     (cond_stop),
        .rise_o     (scl_rise),
        .fall_o     (scl_fall)
    );

    assign mode_legacy = (mode_i == 2'd0);
    assign mode_two    = mode_i[1];
    assign read_dir    = mode_legacy ? st_q.addr[0] : st_q.dev[0];
    assign idx_full    = mode_legacy ? {6'd0, st_q.addr[7:1]} : st_q.addr;
    assign mem_idx     = AW'(idx_full);
    assign is_ack      = (st_q.cnt == 6'd9) || (st_q.cnt == 6'd18) || (st_q.cnt == 6'd27);

    twi_byte_store #(
        .DEPTH  (MEM_BYTES),
        .DATA_W (DATA_W)
    ) u_store (
        .clk_i   (clk_i),
        .we_i    (mem_we),
        .idx_i   (mem_idx),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.scl   = scl_i;
        st_d.sda   = sda_i;
        mem_we     = 1'b0;
        mem_wdata  = {st_q.shreg, sda_i};
        cnt_inc    = st_q.cnt + 6'd1;
        data_phase = mode_two ? (st_q.cnt > 6'd27) : (st_q.cnt > 6'd18);
        addr_sh    = {st_q.addr[11:0], sda_i};
        if (!mode_two) begin
            addr_sh[12:8] = '0;
            if (st_q.cnt == 6'd17) begin
                addr_sh[10:8] = st_q.dev[3:1];
            end
        end

        if (cond_start) begin
            st_d.started = 1'b1;
            st_d.cnt     = '0;
        end else if (cond_stop) begin
            st_d.started = 1'b0;
        end else if (scl_rise) begin
            st_d.cnt = cnt_inc;
            if (mode_legacy) begin
                if (cnt_inc == 6'd18) begin
                    st_d.cnt = 6'd9;
                    if (st_q.addr[0]) begin
                        st_d.addr = {5'd0, st_q.addr[7:0] + 8'd2};
                    end
                end
            end else if (st_q.dev[0] && cnt_inc == 6'd18) begin
                st_d.cnt  = 6'd9;
                st_d.addr = st_q.addr + 13'd1;
            end else if (!mode_two && cnt_inc == 6'd27) begin
                st_d.cnt = 6'd18;
            end else if (cnt_inc == 6'd36) begin
                st_d.cnt = 6'd27;
            end
        end else if (scl_fall) begin
            if (mode_legacy) begin
                if (st_q.cnt > 6'd9) begin
                    if (!st_q.addr[0]) begin
                        st_d.shreg = {st_q.shreg[5:0], sda_i};
                        if (st_q.cnt == 6'd17) begin
                            mem_we         = 1'b1;
                            st_d.addr[2:1] = st_q.addr[2:1] + 2'd1;
                        end
                    end
                end else if (st_q.cnt != 6'd9 && st_q.cnt != 6'd0) begin
                    st_d.addr = {5'd0, st_q.addr[6:0], sda_i};
                end
            end else if (is_ack) begin
                st_d.shreg = st_q.shreg;
            end else if (data_phase) begin
                if (!st_q.dev[0]) begin
                    st_d.shreg = {st_q.shreg[5:0], sda_i};
                    if (st_q.cnt == (mode_two ? 6'd35 : 6'd26)) begin
                        mem_we         = 1'b1;
                        st_d.addr[3:0] = st_q.addr[3:0] + 4'd1;
                    end
                end
            end else if (st_q.cnt > 6'd9) begin
                if (!st_q.dev[0]) begin
                    st_d.addr = addr_sh;
                end
            end else if (st_q.cnt >= 6'd5) begin
                st_d.dev[2'(4'd8 - st_q.cnt[3:0])] = sda_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.scl     <= 1'b1;
            st_q.sda     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_sel = 3'(6'd17 - st_q.cnt);
    assign ack_o   = st_q.started & is_ack;

    always_comb begin
        if (!st_q.started) begin
            sda_rd_o = sda_i;
        end else if (is_ack) begin
            sda_rd_o = 1'b0;
        end else if (read_dir && st_q.cnt > 6'd9 && st_q.cnt < 6'd18) begin
            sda_rd_o = mem_rdata[bit_sel];
        end else begin
            sda_rd_o = sda_i;
        end
    end
endmodule

// File: rtl/twi_eeprom_checks.sv
module twi_eeprom_checks (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_rd_o,
    input logic       ack_o,
    input logic       started_q,
    input logic       scl_q,
    input logic       sda_q,
    input logic [5:0] cnt_q
);
    // R1: start condition arms the device with a zero count
    a_r1_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_q && scl_i && sda_q && !sda_i) |=> (started_q && cnt_q == 6'd0));

    // R2: stop condition disarms the device
    a_r2_stop_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_q && scl_i && !sda_q && sda_i) |=> !started_q);

    // R3: rising clock edges below a fold point add exactly one
    a_r3_rise_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && !scl_q && scl_i && cnt_q < 6'd8) |=> (cnt_q == $past(cnt_q) + 6'd1));

    // R3: an idle device with the clock low keeps its count
    a_r3_idle_count_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!started_q && !scl_i) |=> $stable(cnt_q));

    // R4: acknowledge slots pull the read output low
    a_r4_ack_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> !sda_rd_o);

    // R9: folding keeps the count below 36
    a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= 6'd35);

    // R12: idle output follows the data line
    a_r12_idle_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !started_q |-> (sda_rd_o == sda_i));
endmodule

bind twi_eeprom_slave twi_eeprom_checks u_checks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_rd_o  (sda_rd_o),
    .ack_o     (ack_o),
    .started_q (st_q.started),
    .scl_q     (st_q.scl),
    .sda_q     (st_q.sda),
    .cnt_q     (st_q.cnt)
);

// File: tb/twi_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twi_eeprom_slave_bench;
    localparam int MEM = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       sda_rd, ack;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         cmp_en = 1'b0;

    always #2 clk = ~clk;

    twi_eeprom_slave #(.MEM_BYTES(MEM)) u_twi_eeprom_slave (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .mode_i   (mode),
        .scl_i    (scl),
        .sda_i    (sda),
        .sda_rd_o (sda_rd),
        .ack_o    (ack)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_scl, m_sda, m_st, m_cnt, m_dev, m_addr, m_data;
    byte unsigned m_mem [int];

    function automatic int m_idx();
        return (mode == 2'd0) ? ((m_addr >> 1) & 127) : (m_addr % MEM);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scl = 1; m_sda = 1; m_st = 0; m_cnt = 0; m_dev = 0; m_addr = 0; m_data = 0;
        end else begin
            automatic int lg = (mode == 2'd0);
            automatic int tw = mode[1];
            automatic int b  = sda;
            if (m_scl && scl && m_sda && !sda) begin
                m_st = 1; m_cnt = 0;
            end else if (m_scl && scl && !m_sda && sda) begin
                m_st = 0;
            end else if (m_st && !m_scl && scl) begin
                m_cnt++;
                if (lg) begin
                    if (m_cnt == 18) begin
                        m_cnt = 9;
                        if (m_addr & 1) m_addr = (m_addr + 2) & 255;
                    end
                end else if ((m_dev & 1) && m_cnt == 18) begin
                    m_cnt = 9; m_addr = (m_addr + 1) & 8191;
                end else if (!tw && m_cnt == 27) m_cnt = 18;
                else if (m_cnt == 36) m_cnt = 27;
            end else if (m_st && m_scl && !scl) begin
                if (lg) begin
                    if (m_cnt > 9) begin
                        if (!(m_addr & 1)) begin
                            m_data = ((m_data << 1) | b) & 255;
                            if (m_cnt == 17) begin
                                m_mem[m_idx()] = byte'(m_data);
                                m_addr = (m_addr & 'hF9) | ((m_addr + 2) & 6);
                            end
                        end
                    end else if (m_cnt >= 1 && m_cnt <= 8) m_addr = ((m_addr << 1) | b) & 255;
                end else if (m_cnt == 9 || m_cnt == 18 || m_cnt == 27) begin
                end else if ((tw && m_cnt > 27) || (!tw && m_cnt > 18)) begin
                    if (!(m_dev & 1)) begin
                        m_data = ((m_data << 1) | b) & 255;
                        if (m_cnt == (tw ? 35 : 26)) begin
                            m_mem[m_idx()] = byte'(m_data);
                            m_addr = (m_addr & ~15) | ((m_addr + 1) & 15);
                        end
                    end
                end else if (m_cnt > 9) begin
                    if (!(m_dev & 1)) begin
                        m_addr = ((m_addr << 1) | b) & (tw ? 8191 : 255);
                        if (!tw && m_cnt == 17) m_addr = m_addr | (((m_dev >> 1) & 7) << 8);
                    end
                end else if (m_cnt >= 1) m_dev = ((m_dev << 1) | b) & 255;
            end
            m_scl = scl; m_sda = sda;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && cmp_en) begin
            automatic int lg   = (mode == 2'd0);
            automatic int rdir = lg ? (m_addr & 1) : (m_dev & 1);
            automatic int a_ex = m_st && (m_cnt == 9 || m_cnt == 18 || m_cnt == 27);
            chk("R4", ack, a_ex, "per-cycle ack");
            if (!m_st) chk("R12", sda_rd, sda, "per-cycle idle mirror");
            else if (a_ex) chk("R4", sda_rd, 0, "per-cycle ack level");
            else if (rdir && m_cnt > 9 && m_cnt < 18) begin
                if (m_mem.exists(m_idx()))
                    chk("R12", sda_rd, (m_mem[m_idx()] >> (17 - m_cnt)) & 1, "per-cycle read bit");
            end else chk("R12", sda_rd, sda, "per-cycle open bus");
        end
    end

    // ---------------- bus-level driver ----------------
    task automatic step(input logic c, input logic d);
        @(negedge clk); scl = c; sda = d;
        @(negedge clk);
    endtask

    task automatic bus_start();
        step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    endtask

    task automatic bus_stop();
        step(0, 0); step(1, 0); step(1, 1);
    endtask

    task automatic send_bit(input logic b);
        step(0, b); step(1, b); step(0, b);
    endtask

    task automatic slave_ack(input string what);
        step(0, 1); step(1, 1);
        chk("R4", ack, 1, {what, " ack flag"});
        chk("R3", sda_rd, 0, {what, " ack slot position"});
        step(0, 1);
    endtask

    task automatic send_byte(input logic [7:0] v, input string what);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        slave_ack(what);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic last);
        for (int i = 7; i >= 0; i--) begin
            step(0, 1); step(1, 1);
            v[i] = sda_rd;
            step(0, 1);
        end
        send_bit(last);
    endtask

    task automatic leg_write(input int a, input byte unsigned d[]);
        mode = 2'd0;
        bus_start();
        send_byte({a[6:0], 1'b0}, "R5 legacy write address");
        foreach (d[i]) send_byte(d[i], "R7 legacy data");
        bus_stop();
    endtask

    task automatic leg_read(input int a, input byte unsigned e[], input string req);
        logic [7:0] v;
        mode = 2'd0;
        bus_start();
        send_byte({a[6:0], 1'b1}, "R5 legacy read address");
        foreach (e[i]) begin
            recv_byte(v, i == e.size() - 1);
            chk(req, v, e[i], $sformatf("legacy read byte %0d", i));
        end
        bus_stop();
    endtask

    task automatic send_addr(input logic [1:0] md, input int a);
        if (md[1]) send_byte(8'((a >> 8) & 255), "R8 address high");
        send_byte(8'(a & 255), "R8 address low");
    endtask

    task automatic dev_write(input logic [1:0] md, input logic [7:0] dv, input int a,
                             input byte unsigned d[]);
        mode = md;
        bus_start();
        send_byte({dv[7:1], 1'b0}, "R8 device byte");
        send_addr(md, a);
        foreach (d[i]) send_byte(d[i], "R9 write data");
        bus_stop();
    endtask

    task automatic dev_read(input logic [1:0] md, input logic [7:0] dv, input int a,
                            input byte unsigned e[], input string req);
        logic [7:0] v;
        mode = md;
        bus_start();
        send_byte({dv[7:1], 1'b0}, "R8 device byte");
        send_addr(md, a);
        bus_start();  // R1 repeated start
        send_byte({dv[7:1], 1'b1}, "R1 device byte after repeated start");
        foreach (e[i]) begin
            recv_byte(v, i == e.size() - 1);
            chk(req, v, e[i], $sformatf("device read byte %0d", i));
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4", ack, 0, "reset ack");
        chk("R12", sda_rd, 1, "reset mirror high");
        cmp_en = 1'b1;
        step(0, 1); step(0, 0);
        chk("R12", sda_rd, 0, "idle mirror low");
        step(0, 1);

        // legacy mode
        leg_write(5, '{8'h11, 8'h22});
        leg_read(5, '{8'h11, 8'h22}, "R5");
        leg_write(10, '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4});
        leg_read(8, '{8'hA2, 8'hA3, 8'hA4, 8'hA1}, "R7");
        leg_write(127, '{8'h7E});
        leg_write(0, '{8'h01});
        leg_read(127, '{8'h7E, 8'h01}, "R6");

        // R2: stop mid-transfer, then clock pulses while idle
        mode = 2'd0;
        bus_start();
        send_byte(8'h40, "R2 aborted address");
        bus_stop();
        for (int i = 0; i < 3; i++) begin
            step(0, 1); step(1, 1);
            chk("R2", ack, 0, "idle clock pulse ack");
            chk("R2", sda_rd, 1, "idle clock pulse mirror");
        end
        leg_read(5, '{8'h11}, "R2");

        // two address bytes
        dev_write(2'd2, 8'hA0, 'h123, '{8'hC1, 8'hC2, 8'hC3});
        dev_read(2'd2, 8'hA0, 'h123, '{8'hC1, 8'hC2, 8'hC3}, "R8");
        dev_write(2'd3, 8'hA0, 'h13F, '{8'hD0});
        dev_write(2'd2, 8'hA0, 'h140, '{8'hD1});
        dev_read(2'd2, 8'hA0, 'h13F, '{8'hD0, 8'hD1}, "R9");
        dev_write(2'd2, 8'hA0, 'h14E, '{8'hE0, 8'hE1, 8'hE2});
        dev_read(2'd2, 8'hA0, 'h140, '{8'hE2}, "R10");
        dev_read(2'd2, 8'hA0, 'h14E, '{8'hE0, 8'hE1}, "R10");

        // one address byte with device-bit fold
        dev_write(2'd2, 8'hA0, 'h010, '{8'h33});
        dev_write(2'd1, 8'hA6, 'h10, '{8'h5A});
        dev_read(2'd1, 8'hA6, 'h10, '{8'h5A}, "R11");
        dev_read(2'd2, 8'hA0, 'h010, '{8'h33}, "R11");
        dev_read(2'd2, 8'hA0, 'h310, '{8'h5A}, "R11");
        dev_write(2'd1, 8'hA0, 'h0E, '{8'hF0, 8'hF1, 8'hF2});
        dev_read(2'd2, 8'hA0, 'h000, '{8'hF2}, "R10");
        dev_read(2'd1, 8'hA0, 'h0E, '{8'hF0, 8'hF1}, "R9");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule